// File: doc/BRIEF.md
# Constant-Time Dual Scalar Multiplication Sequencer

This block computes Q = kP + lR by walking two scalars in lockstep, one bit pair per step. It does not do any field arithmetic. It keeps the working points in a small register file. Each point doubling or point addition goes out as a job to an external point-arithmetic unit, over a level request and a single-cycle done handshake.

Each step doubles the accumulator Q and then adds a point chosen by the bit pair. The point is the precomputed sum S = P + R, or P, or R. When both bits are zero, the addition still happens, but it lands in a dummy accumulator T. Q is then left alone. As a result every run issues the same job sequence whatever the scalar values, and the run time depends only on the point unit's latencies.

A start pulse loads the scalars and the two input points. The result appears on the Q outputs together with a one-cycle done pulse. Each stored point carries an explicit infinity flag, and these flags are passed to the point unit along with the coordinates.

Top module: `dual_scalar_seq`

## Requirements
- R1: After reset, done is low, puReq is low and qInf is high (Q holds the point at infinity).
- R2: The first job of every run is an addition (puDbl low) with operand A = P and operand B = R, both flagged finite; its result is kept as S.
- R3: After the precompute job, the block issues NB pairs of jobs, each pair a doubling (puDbl high) followed by an addition (puDbl low). This gives exactly 2*NB+1 jobs per run for any scalar values.
- R4: Bit pairs are consumed from bit NB-1 down to bit 0. The doubling is applied to Q. Pair (k,l) = (1,1) adds S to Q, (1,0) adds P to Q, and (0,1) adds R to Q.
- R5: Pair (0,0) adds S into the dummy accumulator T and leaves Q unchanged; k = l = 0 ends with qInf high.
- R6: puReq stays high, with puDbl and all operand lines stable, until the cycle in which puDone is sampled. Only one job is outstanding at any time.
- R7: done is high for exactly one cycle with puReq low. In that cycle Q equals kP + lR, and Q holds that value until the next run starts.
- R8: A start pulse during a run is ignored: the run's result is unchanged and no extra done pulse is produced.
- R9: At the start of a run, Q and T are set to infinity and P and R are marked finite. The infinity flags travel with each operand to the point unit, and the flag the unit returns is stored with the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| kScalar | input | NB | First scalar k |
| lScalar | input | NB | Second scalar l |
| pX | input | CW | X coordinate of P |
| pY | input | CW | Y coordinate of P |
| rX | input | CW | X coordinate of R |
| rY | input | CW | Y coordinate of R |
| qX | output | CW | X coordinate of result Q |
| qY | output | CW | Y coordinate of result Q |
| qInf | output | 1 | Q is the point at infinity |
| done | output | 1 | One-cycle result-valid pulse |
| puReq | output | 1 | Job request to the point unit (level) |
| puDbl | output | 1 | 1 = doubling of operand A, 0 = addition A + B |
| puAX | output | CW | Operand A X coordinate |
| puAY | output | CW | Operand A Y coordinate |
| puAInf | output | 1 | Operand A infinity flag |
| puBX | output | CW | Operand B X coordinate |
| puBY | output | CW | Operand B Y coordinate |
| puBInf | output | 1 | Operand B infinity flag |
| puDone | input | 1 | Job complete; result valid this cycle |
| puResX | input | CW | Result X coordinate |
| puResY | input | CW | Result Y coordinate |
| puResInf | input | 1 | Result infinity flag |

## Verification
The hardest case to reach from the ports is the dummy addition. It must not disturb Q, yet the job stream looks exactly like a real addition. The bench models point addition as coordinate-wise integer addition modulo 2^CW, with an infinity flag. A corrupted Q therefore always shows up in the final coordinates. The scalars are chosen to put long runs of (0,0) pairs between nonzero pairs: at the top, in the middle and at the bottom. The all-zero pair is also used, which must leave Q at infinity through every step. A start pulse is injected in the middle of a run to show it has no effect.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  // Kind of point job the controller is currently running
  typedef enum logic [1:0] {
    JOB_PRE = 2'd0,   // S = P + R
    JOB_DBL = 2'd1,   // Q = 2Q
    JOB_ADD = 2'd2    // Q or T accumulation selected by the bit pair
  } dsmJob_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic    load;    // capture scalars and points, clear accumulators
    logic    req;     // a job is outstanding
    logic    commit;  // the point unit has returned the result
    dsmJob_e job;     // which job is outstanding
  } dsmCtrl_t;

endpackage

// File: rtl/dsm_ctrl.sv
module dsm_ctrl
  import dsm_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     puDone,
  output dsmCtrl_t ctl,
  output logic     done
);

  localparam int CNTW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [CNTW-1:0] LAST_BIT = CNTW'(NB - 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DBL,
    ST_ADD,
    ST_FIN
  } dsmState_e;

  dsmState_e        state;
  logic [CNTW-1:0]  bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) state <= ST_PRE;
        ST_PRE: if (puDone) begin
          state  <= ST_DBL;
          bitCnt <= '0;
        end
        ST_DBL: if (puDone) state <= ST_ADD;
        ST_ADD: if (puDone) begin
          if (bitCnt == LAST_BIT) begin
            state <= ST_FIN;
          end else begin
            bitCnt <= bitCnt + 1'b1;
            state  <= ST_DBL;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.load   = (state == ST_IDLE) && start;
    ctl.req    = (state == ST_PRE) || (state == ST_DBL) || (state == ST_ADD);
    ctl.commit = ctl.req && puDone;
    unique case (state)
      ST_PRE:  ctl.job = JOB_PRE;
      ST_ADD:  ctl.job = JOB_ADD;
      default: ctl.job = JOB_DBL;
    endcase
  end

  assign done = (state == ST_FIN);

endmodule

// File: rtl/dsm_datapath.sv
module dsm_datapath
  import dsm_pkg::*;
#(
  parameter int NB = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dsmCtrl_t      ctl,
  input  logic [NB-1:0] kScalar,
  input  logic [NB-1:0] lScalar,
  input  logic [CW-1:0] pX,
  input  logic [CW-1:0] pY,
  input  logic [CW-1:0] rX,
  input  logic [CW-1:0] rY,
  output logic [CW-1:0] qX,
  output logic [CW-1:0] qY,
  output logic          qInf,
  output logic          puDbl,
  output logic [CW-1:0] puAX,
  output logic [CW-1:0] puAY,
  output logic          puAInf,
  output logic [CW-1:0] puBX,
  output logic [CW-1:0] puBY,
  output logic          puBInf,
  input  logic [CW-1:0] puResX,
  input  logic [CW-1:0] puResY,
  input  logic          puResInf
);

  // Register file slots
  localparam int NSLOT = 5;
  localparam int SW    = 3;
  localparam logic [SW-1:0] SL_P = 3'd0;
  localparam logic [SW-1:0] SL_R = 3'd1;
  localparam logic [SW-1:0] SL_S = 3'd2;
  localparam logic [SW-1:0] SL_Q = 3'd3;
  localparam logic [SW-1:0] SL_T = 3'd4;

  logic [CW-1:0] rfX   [NSLOT];
  logic [CW-1:0] rfY   [NSLOT];
  logic          rfInf [NSLOT];

  logic [NB-1:0] kSh;
  logic [NB-1:0] lSh;
  logic [SW-1:0] aSel;
  logic [SW-1:0] bSel;
  logic [SW-1:0] dSel;

  // Operand and destination selection; bit pair comes from the scalar MSBs
  always_comb begin
    aSel = SL_Q;
    bSel = SL_Q;
    dSel = SL_Q;
    unique case (ctl.job)
      JOB_PRE: begin
        aSel = SL_P;
        bSel = SL_R;
        dSel = SL_S;
      end
      JOB_ADD: begin
        unique case ({kSh[NB-1], lSh[NB-1]})
          2'b11: begin aSel = SL_Q; bSel = SL_S; dSel = SL_Q; end
          2'b10: begin aSel = SL_Q; bSel = SL_P; dSel = SL_Q; end
          2'b01: begin aSel = SL_Q; bSel = SL_R; dSel = SL_Q; end
          default: begin aSel = SL_T; bSel = SL_S; dSel = SL_T; end
        endcase
      end
      default: begin
        aSel = SL_Q;
        bSel = SL_Q;
        dSel = SL_Q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSLOT; i++) begin
        rfX[i]   <= '0;
        rfY[i]   <= '0;
        rfInf[i] <= 1'b1;
      end
      kSh <= '0;
      lSh <= '0;
    end else if (ctl.load) begin
      rfX[SL_P]   <= pX;
      rfY[SL_P]   <= pY;
      rfInf[SL_P] <= 1'b0;
      rfX[SL_R]   <= rX;
      rfY[SL_R]   <= rY;
      rfInf[SL_R] <= 1'b0;
      rfInf[SL_S] <= 1'b1;
      rfInf[SL_Q] <= 1'b1;
      rfInf[SL_T] <= 1'b1;
      kSh <= kScalar;
      lSh <= lScalar;
    end else if (ctl.commit) begin
      rfX[dSel]   <= puResX;
      rfY[dSel]   <= puResY;
      rfInf[dSel] <= puResInf;
      if (ctl.job == JOB_ADD) begin
        kSh <= {kSh[NB-2:0], 1'b0};
        lSh <= {lSh[NB-2:0], 1'b0};
      end
    end
  end

  assign puDbl  = (ctl.job == JOB_DBL);
  assign puAX   = rfX[aSel];
  assign puAY   = rfY[aSel];
  assign puAInf = rfInf[aSel];
  assign puBX   = rfX[bSel];
  assign puBY   = rfY[bSel];
  assign puBInf = rfInf[bSel];

  assign qX   = rfX[SL_Q];
  assign qY   = rfY[SL_Q];
  assign qInf = rfInf[SL_Q];

endmodule

// File: rtl/dual_scalar_seq.sv
module dual_scalar_seq
  import dsm_pkg::*;
#(
  parameter int NB = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [NB-1:0] kScalar,
  input  logic [NB-1:0] lScalar,
  input  logic [CW-1:0] pX,
  input  logic [CW-1:0] pY,
  input  logic [CW-1:0] rX,
  input  logic [CW-1:0] rY,
  output logic [CW-1:0] qX,
  output logic [CW-1:0] qY,
  output logic          qInf,
  output logic          done,
  output logic          puReq,
  output logic          puDbl,
  output logic [CW-1:0] puAX,
  output logic [CW-1:0] puAY,
  output logic          puAInf,
  output logic [CW-1:0] puBX,
  output logic [CW-1:0] puBY,
  output logic          puBInf,
  input  logic          puDone,
  input  logic [CW-1:0] puResX,
  input  logic [CW-1:0] puResY,
  input  logic          puResInf
);

  dsmCtrl_t ctl;

  dsm_ctrl #(.NB(NB)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .puDone (puDone),
    .ctl    (ctl),
    .done   (done)
  );

  dsm_datapath #(.NB(NB), .CW(CW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .kScalar  (kScalar),
    .lScalar  (lScalar),
    .pX       (pX),
    .pY       (pY),
    .rX       (rX),
    .rY       (rY),
    .qX       (qX),
    .qY       (qY),
    .qInf     (qInf),
    .puDbl    (puDbl),
    .puAX     (puAX),
    .puAY     (puAY),
    .puAInf   (puAInf),
    .puBX     (puBX),
    .puBY     (puBY),
    .puBInf   (puBInf),
    .puResX   (puResX),
    .puResY   (puResY),
    .puResInf (puResInf)
  );

  assign puReq = ctl.req;

endmodule

// File: rtl/dsm_checker.sv
module dsm_checker #(
  parameter int NB = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          done,
  input logic          puReq,
  input logic          puDbl,
  input logic [CW-1:0] puAX,
  input logic [CW-1:0] puAY,
  input logic          puAInf,
  input logic [CW-1:0] puBX,
  input logic [CW-1:0] puBY,
  input logic          puBInf,
  input logic          puDone
);

  localparam int JOBS = 2 * NB + 1;
  localparam int JW   = $clog2(JOBS + 1);

  logic [JW-1:0] jobsDone;

  always_ff @(posedge clk) begin
    if (!rstN)                jobsDone <= '0;
    else if (done)            jobsDone <= '0;
    else if (puReq && puDone) jobsDone <= jobsDone + 1'b1;
  end

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (puReq && !puDone) |=> (puReq && $stable(puDbl) && $stable(puAX) && $stable(puAY)
                            && $stable(puAInf) && $stable(puBX) && $stable(puBY) && $stable(puBInf)));

  // R3
  job_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    puReq |-> (puDbl == jobsDone[0]));

  // R3
  job_total_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (jobsDone == JW'(JOBS)));

  // R2
  pre_operands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (puReq && jobsDone == '0) |-> (!puDbl && !puAInf && !puBInf));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !puReq);

endmodule

bind dual_scalar_seq dsm_checker #(.NB(NB), .CW(CW)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .done   (done),
  .puReq  (puReq),
  .puDbl  (puDbl),
  .puAX   (puAX),
  .puAY   (puAY),
  .puAInf (puAInf),
  .puBX   (puBX),
  .puBY   (puBY),
  .puBInf (puBInf),
  .puDone (puDone)
);

// File: tb/sim_dual_scalar_seq.sv
`timescale 1ns/1ps
module sim_dual_scalar_seq;

  localparam int NB   = 8;
  localparam int CW   = 16;
  localparam int LADD = 6;
  localparam int LDBL = 4;
  localparam int JOBS = 2 * NB + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [NB-1:0] kScalar = '0;
  logic [NB-1:0] lScalar = '0;
  logic [CW-1:0] pX = '0, pY = '0, rX = '0, rY = '0;
  logic [CW-1:0] qX, qY;
  logic          qInf, done;
  logic          puReq, puDbl, puAInf, puBInf;
  logic [CW-1:0] puAX, puAY, puBX, puBY;
  logic          puDone = 1'b0;
  logic [CW-1:0] puResX = '0, puResY = '0;
  logic          puResInf = 1'b0;

  always #2.5 clk = ~clk;

  dual_scalar_seq #(.NB(NB), .CW(CW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .kScalar(kScalar), .lScalar(lScalar),
    .pX(pX), .pY(pY), .rX(rX), .rY(rY), .qX(qX), .qY(qY), .qInf(qInf), .done(done),
    .puReq(puReq), .puDbl(puDbl), .puAX(puAX), .puAY(puAY), .puAInf(puAInf),
    .puBX(puBX), .puBY(puBY), .puBInf(puBInf), .puDone(puDone),
    .puResX(puResX), .puResY(puResY), .puResInf(puResInf)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- point unit model: coordinate-wise add mod 2^CW ----------------
  int            jobTotal = 0;
  int            orderErr = 0;
  int            holdErr  = 0;
  int            preErr   = 0;
  bit            muBusy   = 0;
  int            muCnt    = 0;
  logic          latDbl;
  logic [CW-1:0] latAX, latAY, latBX, latBY;
  logic          latAInf, latBInf;

  always @(posedge clk) begin
    if (!rstN) begin
      muBusy <= 0;
      puDone <= 1'b0;
    end else if (puDone) begin
      puDone <= 1'b0;
    end else if (muBusy) begin
      if (!puReq || puDbl != latDbl || puAX != latAX || puAY != latAY || puAInf != latAInf
          || puBX != latBX || puBY != latBY || puBInf != latBInf)
        holdErr <= holdErr + 1;
      if (muCnt == 1) begin
        muBusy <= 0;
        puDone <= 1'b1;
      end else begin
        muCnt <= muCnt - 1;
      end
    end else if (puReq) begin
      if (puDbl != 1'(jobTotal % JOBS % 2)) orderErr <= orderErr + 1;
      if ((jobTotal % JOBS) == 0 && (puAX != pX || puBX != rX || puAInf || puBInf))
        preErr <= preErr + 1;
      jobTotal <= jobTotal + 1;
      latDbl <= puDbl; latAX <= puAX; latAY <= puAY; latAInf <= puAInf;
      latBX <= puBX; latBY <= puBY; latBInf <= puBInf;
      muBusy <= 1;
      muCnt  <= puDbl ? LDBL : LADD;
      if (puDbl) begin
        puResInf <= puAInf;
        puResX   <= CW'(puAX + puAX);
        puResY   <= CW'(puAY + puAY);
      end else if (puAInf) begin
        puResInf <= puBInf; puResX <= puBX; puResY <= puBY;
      end else if (puBInf) begin
        puResInf <= 1'b0; puResX <= puAX; puResY <= puAY;
      end else begin
        puResInf <= 1'b0;
        puResX   <= CW'(puAX + puBX);
        puResY   <= CW'(puAY + puBY);
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [CW-1:0] x;
    logic [CW-1:0] y;
    logic          inf;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int       doneCount = 0;
  int       pushCount = 0;
  int       lastJobs  = 0;
  int       lastOrder = 0;
  int       lastHold  = 0;
  int       lastPre   = 0;
  bit       prevDone  = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone) chk(!done, "R7 done width", done, 0);
      if (done) begin
        doneCount++;
        if (expQ.size() == 0) begin
          chk(0, "R8 unexpected done", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(qInf == e.inf, {"R5 R9 qInf ", e.tag}, qInf, e.inf);
          if (!e.inf) begin
            chk(qX == e.x, {"R4 qX ", e.tag}, qX, e.x);
            chk(qY == e.y, {"R4 qY ", e.tag}, qY, e.y);
          end
          chk(jobTotal - lastJobs == JOBS, {"R3 job count ", e.tag}, jobTotal - lastJobs, JOBS);
          chk(orderErr == lastOrder, {"R3 job order ", e.tag}, orderErr - lastOrder, 0);
          chk(holdErr == lastHold, {"R6 request hold ", e.tag}, holdErr - lastHold, 0);
          chk(preErr == lastPre, {"R2 precompute operands ", e.tag}, preErr - lastPre, 0);
          chk(!puReq, "R7 idle at done", puReq, 0);
        end
        lastJobs = jobTotal; lastOrder = orderErr; lastHold = holdErr; lastPre = preErr;
      end
      prevDone = done;
    end
  end

  // ---------------- driver ----------------
  task automatic runJob(input logic [NB-1:0] k, input logic [NB-1:0] l,
                        input logic [CW-1:0] px, input logic [CW-1:0] py,
                        input logic [CW-1:0] rx, input logic [CW-1:0] ry,
                        input bit injectStart, input string tag);
    expItem_t e;
    int target;
    e.inf = (k == 0) && (l == 0);
    e.x   = CW'(longint'(k) * px + longint'(l) * rx);
    e.y   = CW'(longint'(k) * py + longint'(l) * ry);
    e.tag = tag;
    expQ.push_back(e);
    pushCount++;
    target = doneCount + 1;
    @(negedge clk);
    kScalar = k; lScalar = l; pX = px; pY = py; rX = rx; rY = ry;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (injectStart) begin
      // R8: new operands and a start pulse while the run is in flight
      repeat (30) @(negedge clk);
      kScalar = ~k; lScalar = ~l; pX = px + 16'd7; rX = rx + 16'd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCount < target) @(negedge clk);
    repeat (5) @(negedge clk);
    // R7: result held after the pulse
    if (!e.inf) chk(qX == e.x && qY == e.y, {"R7 hold ", tag}, qX, e.x);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1 done", done, 0);
    chk(puReq == 1'b0, "R1 puReq", puReq, 0);
    chk(qInf == 1'b1, "R1 qInf", qInf, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runJob(8'hA5, 8'h3C, 16'h1234, 16'h0F0F, 16'h2222, 16'h0101, 0, "mixed");
    runJob(8'h00, 8'h00, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 0, "zero pair R5");
    runJob(8'hFF, 8'hFF, 16'hFFF1, 16'h8001, 16'h7FFF, 16'h0003, 0, "all ones");
    runJob(8'h01, 8'h00, 16'h4321, 16'h0BAD, 16'h5555, 16'h6666, 0, "P only");
    runJob(8'h00, 8'h01, 16'h4321, 16'h0BAD, 16'h5555, 16'h6666, 0, "R only");
    runJob(8'h80, 8'h01, 16'h0003, 16'h0005, 16'h0007, 16'h000B, 0, "sparse ends");
    runJob(8'h10, 8'h08, 16'hABCD, 16'h1357, 16'h2468, 16'h9999, 0, "sparse middle");
    runJob(8'h5A, 8'h00, 16'h0042, 16'h0017, 16'h0000, 16'h0000, 1, "start while busy R8");
    repeat (200) @(negedge clk);
    chk(doneCount == pushCount, "R8 done count", doneCount, pushCount);
    chk(done == 1'b0 && puReq == 1'b0, "R8 idle after ignored start", puReq, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule